// File: doc/BRIEF.md
# Conversion Result Buffer

This block holds converter results between the moment a channel pair finishes converting and the moment a host collects them. A write strobe delivers one pair index together with the two results of that pair. A read strobe then returns one 16-bit word that carries a result, the channel it belongs to, and a flag that says whether the result is fresh.

The same six-entry array serves two layouts. In the channel layout each entry belongs to one channel. The host can read a chosen channel, or it can step through all six channels with an internal pointer. In the queue layout the entries form a ring that keeps results in arrival order. A single pair can then park three unread results per channel. The mode code present during a write chooses the layout. The mode code present during a read chooses the read behaviour.

Top module: `conv_result_buf`

## Requirements
- R1: The read word has the fresh flag in bit 15, the channel number in bits 14:12 and the result in bits 11:0. Pair codes 0, 1 and 2 name pairs A, B and C. The first result of pair p goes to channel 2p and the second to channel 2p+1, so channels 0 to 5 are A0, A1, B0, B1, C0, C1.
- R2: After reset, rd_word is zero and ovf is low. Every entry reads as zero with the fresh flag low, the queue is empty and the step pointer is at channel 0.
- R3: A write whose mode code is not 7 stores both results in their channel entries and marks them fresh. A read with mode code 0 to 5 returns that entry and clears its fresh flag, so a second read returns the same result with bit 15 low.
- R4: A read updates rd_word at the clock edge that samples rd_en. rd_word keeps its value on every cycle without a read.
- R5: Each read with mode code 6 returns the entry under the step pointer and then moves the pointer on by one, from channel 5 back to channel 0.
- R6: A write with mode code 7 appends the first result and then the second. Reads with mode code 7 return queued results oldest first, across different pairs.
- R7: The queue holds six results, so three writes from one pair are all kept and read back in order.
- R8: A queue write that finds fewer than two free entries is discarded and sets ovf. ovf then stays high until reset, and the discarded results never appear.
- R9: A mode-7 read from an empty queue returns an all-zero word.
- R10: The first queue write after channel-layout use drops the fresh flag of every entry. A channel write after queue use empties the queue.
- R11: When a read and a write fall in the same cycle, the read returns the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one pair of results |
| wr_pair | input | 2 | Pair index of the write (0 = A, 1 = B, 2 = C) |
| wr_x0 | input | 12 | First result of the pair |
| wr_x1 | input | 12 | Second result of the pair |
| rd_en | input | 1 | Read strobe |
| rd_mode | input | 3 | 0 to 5 select a channel, 6 selects stepping, 7 selects the queue; also picks the layout of a write |
| rd_word | output | 16 | Packed read word |
| ovf | output | 1 | Sticky flag for discarded queue writes |

## Verification
The bench builds the block with the default parameters: 12-bit results and three pairs. That gives six entries and a 3-bit mode code in which 6 and 7 are the stepping and queue codes. With only six entries, a few writes are enough to fill the queue, to drop two writes against a full queue and an almost full one, and to carry both queue pointers and the step pointer across their wrap point. The switches between the two layouts are reached in both directions.

// File: rtl/crb_pkg.sv
package crb_pkg;

  typedef enum logic [1:0] {
    RK_DIRECT = 2'd0,
    RK_CYCLE  = 2'd1,
    RK_FIFO   = 2'd2
  } rd_kind_e;

  // modular add for ring indices
  function automatic int unsigned wrap_add(input int unsigned v,
                                           input int unsigned step,
                                           input int unsigned n);
    int unsigned s;
    s = v + step;
    return (s >= n) ? s - n : s;
  endfunction

endpackage

// File: rtl/crb_store.sv
module crb_store #(
  parameter int DATA_W = 12,
  parameter int CH     = 6,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_all,
  input  logic              wa_en,
  input  logic [IDX_W-1:0]  wa_idx,
  input  logic [IDX_W-1:0]  wa_tag,
  input  logic [DATA_W-1:0] wa_data,
  input  logic              wb_en,
  input  logic [IDX_W-1:0]  wb_idx,
  input  logic [IDX_W-1:0]  wb_tag,
  input  logic [DATA_W-1:0] wb_data,
  input  logic              rc_en,
  input  logic [IDX_W-1:0]  rc_idx,
  output logic [DATA_W-1:0] data_q [CH],
  output logic [IDX_W-1:0]  tag_q  [CH],
  output logic              vld_q  [CH]
);

  for (genvar i = 0; i < CH; i++) begin : g_ent
    logic              hit_a, hit_b, ld;
    logic              v_n, v_q;
    logic [DATA_W-1:0] d_n, d_q;
    logic [IDX_W-1:0]  t_n, t_q;

    always_comb begin
      hit_a = wa_en && (wa_idx == IDX_W'(i));
      hit_b = wb_en && (wb_idx == IDX_W'(i));
      ld    = hit_a || hit_b;
      v_n   = v_q;
      d_n   = d_q;
      t_n   = t_q;
      if (clr_all || (rc_en && (rc_idx == IDX_W'(i)))) v_n = 1'b0;
      if (hit_a) begin
        v_n = 1'b1;
        d_n = wa_data;
        t_n = wa_tag;
      end
      if (hit_b) begin
        v_n = 1'b1;
        d_n = wb_data;
        t_n = wb_tag;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= '0;
        t_q <= '0;
      end else begin
        v_q <= v_n;
        if (ld) begin
          d_q <= d_n;
          t_q <= t_n;
        end
      end
    end

    assign vld_q[i]  = v_q;
    assign data_q[i] = d_q;
    assign tag_q[i]  = t_q;
  end

endmodule

// File: rtl/crb_fifo_ptr.sv
module crb_fifo_ptr #(
  parameter int CH    = 6,
  parameter int IDX_W = 3,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  output logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] tail0,
  output logic [IDX_W-1:0] tail1,
  output logic [CNT_W-1:0] count,
  output logic             accept,
  output logic             empty,
  output logic             ovf
);
  import crb_pkg::*;

  logic [IDX_W-1:0] head_q, head_n, tail_q, tail_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             ovf_q, ovf_n, pop_ok, upd;

  always_comb begin
    empty  = (cnt_q == '0);
    pop_ok = pop && !empty;
    accept = push && ((32'(cnt_q) + 2) <= CH);
    head_n = pop_ok ? IDX_W'(wrap_add(32'(head_q), 1, CH)) : head_q;
    tail_n = accept ? IDX_W'(wrap_add(32'(tail_q), 2, CH)) : tail_q;
    cnt_n  = cnt_q + (accept ? CNT_W'(2) : '0) - (pop_ok ? CNT_W'(1) : '0);
    if (flush) begin
      head_n = '0;
      tail_n = '0;
      cnt_n  = '0;
    end
    ovf_n  = ovf_q || (push && !accept);
    upd    = flush || accept || pop_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (upd) begin
        head_q <= head_n;
        tail_q <= tail_n;
        cnt_q  <= cnt_n;
      end
      ovf_q <= ovf_n;
    end
  end

  assign head  = head_q;
  assign tail0 = tail_q;
  assign tail1 = IDX_W'(wrap_add(32'(tail_q), 1, CH));
  assign count = cnt_q;
  assign ovf   = ovf_q;

endmodule

// File: rtl/crb_cyc_ptr.sv
module crb_cyc_ptr #(
  parameter int CH    = 6,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);
  import crb_pkg::*;

  logic [IDX_W-1:0] ptr_q, ptr_n;

  always_comb begin
    ptr_n = IDX_W'(wrap_add(32'(ptr_q), 1, CH));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else if (adv) ptr_q <= ptr_n;
  end

  assign ptr = ptr_q;

endmodule

// File: rtl/conv_result_buf.sv
module conv_result_buf #(
  parameter  int DATA_W = 12,
  parameter  int PAIRS  = 3,
  localparam int CH     = 2 * PAIRS,
  localparam int IDX_W  = $clog2(CH),
  localparam int PAIR_W = $clog2(PAIRS),
  localparam int MODE_W = $clog2(CH + 2),
  localparam int CNT_W  = $clog2(CH + 1),
  localparam int WORD_W = 1 + IDX_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PAIR_W-1:0] wr_pair,
  input  logic [DATA_W-1:0] wr_x0,
  input  logic [DATA_W-1:0] wr_x1,
  input  logic              rd_en,
  input  logic [MODE_W-1:0] rd_mode,
  output logic [WORD_W-1:0] rd_word,
  output logic              ovf
);
  import crb_pkg::*;

  localparam int CYC_CODE  = CH;
  localparam int FIFO_CODE = CH + 1;

  // reset: asserted at once, released on the clock
  logic [1:0] rs_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  // write side
  logic             wr_ok, fifo_wr, chan_wr, layout_q, layout_n, clr_all;
  logic [IDX_W-1:0] base_ch;
  logic             wa_en, wb_en;
  logic [IDX_W-1:0] wa_idx, wb_idx;

  // queue pointers and step pointer
  logic [IDX_W-1:0] f_head, f_tail0, f_tail1, cyc_ptr;
  logic [CNT_W-1:0] f_cnt;
  logic             f_accept, f_empty, f_ovf, f_pop, cyc_adv;

  // storage view
  logic [DATA_W-1:0] data_q [CH];
  logic [IDX_W-1:0]  tag_q  [CH];
  logic              vld_q  [CH];

  // read side
  rd_kind_e          kind;
  logic [IDX_W-1:0]  sel;
  logic              rd_hit;
  logic [WORD_W-1:0] word_n, word_q;

  always_comb begin
    wr_ok    = wr_en && (32'(wr_pair) < PAIRS);
    fifo_wr  = wr_ok && (32'(rd_mode) == FIFO_CODE);
    chan_wr  = wr_ok && !(32'(rd_mode) == FIFO_CODE);
    base_ch  = IDX_W'({wr_pair, 1'b0});
    clr_all  = (fifo_wr && !layout_q) || (chan_wr && layout_q);
    layout_n = layout_q;
    if (fifo_wr) layout_n = 1'b1;
    if (chan_wr) layout_n = 1'b0;
    wa_en    = chan_wr || (fifo_wr && f_accept);
    wb_en    = wa_en;
    wa_idx   = chan_wr ? base_ch : f_tail0;
    wb_idx   = chan_wr ? (base_ch | IDX_W'(1)) : f_tail1;
  end

  always_comb begin
    if (32'(rd_mode) < CH)             kind = RK_DIRECT;
    else if (32'(rd_mode) == CYC_CODE) kind = RK_CYCLE;
    else                               kind = RK_FIFO;
    case (kind)
      RK_DIRECT: sel = IDX_W'(rd_mode);
      RK_CYCLE:  sel = cyc_ptr;
      default:   sel = f_head;
    endcase
    rd_hit  = rd_en && !((kind == RK_FIFO) && f_empty);
    word_n  = rd_hit ? {vld_q[sel], tag_q[sel], data_q[sel]} : '0;
    f_pop   = rd_en && (kind == RK_FIFO);
    cyc_adv = rd_en && (kind == RK_CYCLE);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      word_q   <= '0;
      layout_q <= 1'b0;
    end else begin
      if (rd_en) word_q <= word_n;
      if (wr_ok) layout_q <= layout_n;
    end
  end

  crb_store #(
    .DATA_W (DATA_W),
    .CH     (CH),
    .IDX_W  (IDX_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clr_all (clr_all),
    .wa_en   (wa_en),
    .wa_idx  (wa_idx),
    .wa_tag  (base_ch),
    .wa_data (wr_x0),
    .wb_en   (wb_en),
    .wb_idx  (wb_idx),
    .wb_tag  (base_ch | IDX_W'(1)),
    .wb_data (wr_x1),
    .rc_en   (rd_hit),
    .rc_idx  (sel),
    .data_q  (data_q),
    .tag_q   (tag_q),
    .vld_q   (vld_q)
  );

  crb_fifo_ptr #(
    .CH    (CH),
    .IDX_W (IDX_W),
    .CNT_W (CNT_W)
  ) u_fifo (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .flush  (chan_wr),
    .push   (fifo_wr),
    .pop    (f_pop),
    .head   (f_head),
    .tail0  (f_tail0),
    .tail1  (f_tail1),
    .count  (f_cnt),
    .accept (f_accept),
    .empty  (f_empty),
    .ovf    (f_ovf)
  );

  crb_cyc_ptr #(
    .CH    (CH),
    .IDX_W (IDX_W)
  ) u_cyc (
    .clk   (clk),
    .rst_n (rst_int_n),
    .adv   (cyc_adv),
    .ptr   (cyc_ptr)
  );

  assign rd_word = word_q;
  assign ovf     = f_ovf;

endmodule

// File: rtl/crb_chk.sv
module crb_chk #(
  parameter int CH     = 6,
  parameter int IDX_W  = 3,
  parameter int MODE_W = 3,
  parameter int CNT_W  = 3,
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [MODE_W-1:0] rd_mode,
  input logic [WORD_W-1:0] rd_word,
  input logic              ovf,
  input logic [CNT_W-1:0]  f_cnt,
  input logic              f_empty,
  input logic [IDX_W-1:0]  cyc_ptr
);

  logic is_q, is_cyc;
  assign is_q   = (32'(rd_mode) == CH + 1);
  assign is_cyc = (32'(rd_mode) == CH);

  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);

  a_r8_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(wr_en && is_q));

  a_r4_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_word));

  a_r9_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && is_q && f_empty) |=> (rd_word == '0));

  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    32'(f_cnt) <= CH);

  a_r5_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cyc_ptr) < CH);

  a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && is_cyc) |=>
      (32'(cyc_ptr) == ((32'($past(cyc_ptr)) == CH - 1) ? 0 : 32'($past(cyc_ptr)) + 1)));

endmodule

bind conv_result_buf crb_chk #(
  .CH     (CH),
  .IDX_W  (IDX_W),
  .MODE_W (MODE_W),
  .CNT_W  (CNT_W),
  .WORD_W (WORD_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_int_n),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .rd_mode (rd_mode),
  .rd_word (rd_word),
  .ovf     (ovf),
  .f_cnt   (f_cnt),
  .f_empty (f_empty),
  .cyc_ptr (cyc_ptr)
);

// File: tb/sim_conv_result_buf.sv
module sim_conv_result_buf;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_pair = 2'd0;
  logic [11:0] wr_x0 = 12'd0;
  logic [11:0] wr_x1 = 12'd0;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_mode = 3'd0;
  logic [15:0] rd_word;
  logic        ovf;

  always #2 clk = ~clk;

  conv_result_buf u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_pair (wr_pair),
    .wr_x0   (wr_x0),
    .wr_x1   (wr_x1),
    .rd_en   (rd_en),
    .rd_mode (rd_mode),
    .rd_word (rd_word),
    .ovf     (ovf)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [15:0] exp_q[$];
  string       req_q[$];
  logic        rd_fire = 1'b0;

  task automatic check(input bit ok, input string req,
                       input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: a read registered at the last edge is compared here
  always @(posedge clk) rd_fire <= rd_en;

  always @(negedge clk) begin
    if (rd_fire) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "scoreboard-empty", rd_word, 16'h0000);
      end else begin
        logic [15:0] e;
        string       r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        check(rd_word === e, r, rd_word, e);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] p, input logic [11:0] a,
                    input logic [11:0] b, input logic [2:0] m);
    wr_en = 1'b1; wr_pair = p; wr_x0 = a; wr_x1 = b; rd_mode = m;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] m, input logic [15:0] e, input string r);
    exp_q.push_back(e);
    req_q.push_back(r);
    rd_en = 1'b1; rd_mode = m;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R2: reset state
    check(rd_word === 16'h0000, "R2", rd_word, 16'h0000);
    check(ovf === 1'b0, "R2", {15'd0, ovf}, 16'h0000);
    rd(3'd3, 16'h0000, "R2");
    rd(3'd7, 16'h0000, "R9");

    // R3 / R1: channel write, direct reads
    wr(2'd1, 12'h123, 12'h456, 3'd0);
    rd(3'd2, 16'hA123, "R3");
    rd(3'd3, 16'hB456, "R1");
    rd(3'd2, 16'h2123, "R3");

    // R4: word held without reads
    idle(3);
    check(rd_word === 16'h2123, "R4", rd_word, 16'h2123);

    // R5: step through all channels with wrap
    wr(2'd0, 12'h0A0, 12'h0A1, 3'd0);
    wr(2'd1, 12'h0B0, 12'h0B1, 3'd0);
    wr(2'd2, 12'h0C0, 12'h0C1, 3'd0);
    rd(3'd6, 16'h80A0, "R5");
    rd(3'd6, 16'h90A1, "R5");
    rd(3'd6, 16'hA0B0, "R5");
    rd(3'd6, 16'hB0B1, "R5");
    rd(3'd6, 16'hC0C0, "R1");
    rd(3'd6, 16'hD0C1, "R1");
    rd(3'd6, 16'h00A0, "R5");

    // R10 / R6: queue takes over, order across pairs
    wr(2'd1, 12'h5A5, 12'h6B6, 3'd0);
    wr(2'd2, 12'h111, 12'h222, 3'd7);
    rd(3'd3, 16'h36B6, "R10");
    wr(2'd0, 12'h333, 12'h444, 3'd7);
    rd(3'd7, 16'hC111, "R6");
    rd(3'd7, 16'hD222, "R6");
    rd(3'd7, 16'h8333, "R6");
    rd(3'd7, 16'h9444, "R6");
    rd(3'd7, 16'h0000, "R9");

    // R10: channel write empties the queue
    wr(2'd1, 12'h777, 12'h888, 3'd7);
    wr(2'd2, 12'h999, 12'hAAA, 3'd0);
    rd(3'd7, 16'h0000, "R10");
    rd(3'd4, 16'hC999, "R10");
    rd(3'd5, 16'hDAAA, "R10");

    // R7 / R8: fill, overflow, drain
    check(ovf === 1'b0, "R8", {15'd0, ovf}, 16'h0000);
    wr(2'd0, 12'h101, 12'h102, 3'd7);
    wr(2'd0, 12'h103, 12'h104, 3'd7);
    wr(2'd0, 12'h105, 12'h106, 3'd7);
    check(ovf === 1'b0, "R7", {15'd0, ovf}, 16'h0000);
    wr(2'd0, 12'h1FF, 12'h1FE, 3'd7);
    check(ovf === 1'b1, "R8", {15'd0, ovf}, 16'h0001);
    rd(3'd7, 16'h8101, "R7");
    wr(2'd0, 12'h1EE, 12'h1ED, 3'd7);
    rd(3'd7, 16'h9102, "R7");
    rd(3'd7, 16'h8103, "R7");
    rd(3'd7, 16'h9104, "R7");
    rd(3'd7, 16'h8105, "R7");
    rd(3'd7, 16'h9106, "R7");
    rd(3'd7, 16'h0000, "R8");
    check(ovf === 1'b1, "R8", {15'd0, ovf}, 16'h0001);

    // R11: read and write in one cycle
    wr(2'd0, 12'h010, 12'h020, 3'd0);
    exp_q.push_back(16'h8010);
    req_q.push_back("R11");
    wr_en = 1'b1; wr_pair = 2'd0; wr_x0 = 12'h030; wr_x1 = 12'h040;
    rd_en = 1'b1; rd_mode = 3'd0;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    rd(3'd0, 16'h8030, "R11");
    rd(3'd1, 16'h9040, "R11");

    idle(3);
    check(exp_q.size() == 0, "scoreboard-drain", 16'(exp_q.size()), 16'h0000);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0000, 16'h0001);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule